// File: doc/BRIEF.md
# Dual-Mode Colour Palette Register File

This block holds the colour palette that a host programs through four byte-wide ports: one index port and three colour ports. A mode input from the neighbouring mode-control logic decides what those ports mean. In the 8-colour (digital) mode, each port reads and writes one packed byte that carries two 3-bit colour codes. In the 16-colour (analog) mode, the index port picks one of sixteen table entries. The three colour ports then read and write the green, red and blue 4-bit levels of that entry.

Every write that changes a bit the display uses raises a one-cycle redraw request. A write that leaves those bits as they were raises nothing. At reset both personalities are loaded with their defaults. A bulk-load request rewrites all sixteen analog entries from the default table, one entry per clock. Host writes are dropped while the bulk load runs.

Top module: `pal_regfile`

## Requirements
- R1: After reset, digital readback of ports 0, 1, 2 and 3 gives 0x37, 0x15, 0x26 and 0x04, and the index register reads 0.
- R2: With `analog_en` low, a write to port 0, 1, 2 or 3 stores the whole byte in packed slot 3, 1, 2 or 0 respectively, and a port reads back the slot it writes.
- R3: A digital write pulses `redraw` in the cycle after the write edge exactly when (old XOR new) AND 0x77 is non-zero.
- R4: With `analog_en` high, a write to port 0 stores all 8 bits as the index, and reading port 0 returns them.
- R5: With `analog_en` high, ports 1, 2 and 3 write the low nibble of `wdata` as the green, red and blue level of the selected entry. They read back as {4'b0000, level}.
- R6: An analog colour write pulses `redraw` in the next cycle exactly when the stored 4-bit level changes.
- R7: Default entry i (12 bits, green in 11:8, red in 7:4, blue in 3:0) is 0x444 for i = 8. For other i, green is on when i bit 2 is set, red when bit 1 is set and blue when bit 0 is set. An on level is 7 when i < 8 and 15 when i > 8; an off level is 0.
- R8: A `bulk_load` seen while idle holds `bulk_busy` high for exactly 16 cycles and rewrites every entry to its default. It gives one `redraw` pulse, in the cycle `bulk_busy` falls, if and only if some entry changed.
- R9: While `bulk_busy` is high, host writes change no digital slot, no entry and not the index, and raise no `redraw`.
- R10: Digital writes leave the analog table untouched, and analog writes leave the digital slots untouched.
- R11: Only index bits 3:0 select the entry, so indices that differ only in bits 7:4 address the same entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| analog_en | input | 1 | 1 selects the 16-entry analog personality |
| wr_en | input | 1 | Host write strobe |
| addr | input | 2 | Port select: 0 index/slot, 1..3 colour ports |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Readback of the addressed port, combinational |
| bulk_load | input | 1 | Request to reload the analog table with defaults |
| bulk_busy | output | 1 | High while the bulk reload runs |
| redraw | output | 1 | One-cycle redraw request |

## Verification
A wrong slot mapping or a stale entry shows at `rdata` as soon as the affected port is addressed. The combinational readback means it appears in the same cycle. A faulty change mask or nibble compare shows one cycle after the offending write, as a missing or extra `redraw` pulse. A miscounted or leaky bulk sequence shows in three ways: as a busy window that is not 16 cycles long, as a final pulse that does not match whether the table differed from its defaults, or as host data that survives the reload.

// File: rtl/palreg_pkg.sv
package palreg_pkg;
  localparam int COMP_W  = 4;
  localparam int ENT_W   = 3 * COMP_W;
  localparam int BYTE_W  = 8;
  localparam int NUM_DIG = 4;

  typedef logic [ENT_W-1:0] pal_ent_t;

  // default analog entry: bit2 -> green, bit1 -> red, bit0 -> blue
  function automatic pal_ent_t dflt_entry(input int unsigned i);
    logic [31:0]       iv;
    logic [COMP_W-1:0] lvl;
    pal_ent_t          e;
    iv  = i;
    lvl = (iv < 32'd8) ? COMP_W'(7) : COMP_W'(15);
    e   = '0;
    if (iv == 32'd8) begin
      e = 12'h444;
    end else begin
      e[3*COMP_W-1:2*COMP_W] = iv[2] ? lvl : '0;
      e[2*COMP_W-1:COMP_W]   = iv[1] ? lvl : '0;
      e[COMP_W-1:0]          = iv[0] ? lvl : '0;
    end
    return e;
  endfunction

  function automatic logic [BYTE_W-1:0] dig_default(input int unsigned b);
    return BYTE_W'(32'h04 + 32'h11 * b);
  endfunction

  // port -> packed slot: 0->3, 1->1, 2->2, 3->0
  function automatic logic [1:0] port_slot(input logic [1:0] p);
    return (p[0] == p[1]) ? ~p : p;
  endfunction
endpackage

// File: rtl/pal_digital.sv
module pal_digital
  import palreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        port,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd,
  output logic              chg
);
  localparam logic [BYTE_W-1:0] USED_MASK = 8'h77;

  logic [BYTE_W-1:0] slot_q [NUM_DIG];
  logic [1:0]        sel;

  assign sel = port_slot(port);
  assign rd  = slot_q[sel];
  assign chg = we && (|((rd ^ wdata) & USED_MASK));

  for (genvar g = 0; g < NUM_DIG; g++) begin : g_slot
    logic en;
    always_comb en = we && (sel == 2'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  slot_q[g] <= dig_default(g);
      else if (en) slot_q[g] <= wdata;
    end
  end
endmodule

// File: rtl/pal_table.sv
module pal_table
  import palreg_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int IW        = $clog2(N_ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [2:0]    wmask,   // [2] green, [1] red, [0] blue
  input  pal_ent_t      wval,
  input  logic [IW-1:0] ridx,
  output pal_ent_t      rent,
  output logic          diff
);
  pal_ent_t ent_q [N_ENTRIES];
  pal_ent_t bmask;
  pal_ent_t old;

  assign bmask = {{COMP_W{wmask[2]}}, {COMP_W{wmask[1]}}, {COMP_W{wmask[0]}}};
  assign old   = ent_q[widx];
  assign diff  = we && (|((old ^ wval) & bmask));
  assign rent  = ent_q[ridx];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic     en;
    pal_ent_t d;
    always_comb begin
      en = we && (widx == IW'(g));
      d  = (ent_q[g] & ~bmask) | (wval & bmask);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ent_q[g] <= dflt_entry(g);
      else if (en) ent_q[g] <= d;
    end
  end
endmodule

// File: rtl/pal_bulk.sv
module pal_bulk #(
  parameter int N_ENTRIES = 16,
  parameter int IW        = $clog2(N_ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          tbl_diff,
  output logic          busy,
  output logic          ld_we,
  output logic [IW-1:0] ld_idx,
  output logic          fire
);
  logic          busy_q, busy_d;
  logic [IW-1:0] cnt_q, cnt_d;
  logic          seen_q, seen_d;
  logic          last;

  always_comb begin
    last   = busy_q && (cnt_q == IW'(N_ENTRIES - 1));
    busy_d = busy_q ? !last : start;
    cnt_d  = (busy_q && !last) ? cnt_q + 1'b1 : '0;
    seen_d = busy_q && !last && (seen_q || tbl_diff);
    fire   = last && (seen_q || tbl_diff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  assign busy   = busy_q;
  assign ld_we  = busy_q;
  assign ld_idx = cnt_q;
endmodule

// File: rtl/pal_regfile.sv
module pal_regfile
  import palreg_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       analog_en,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       bulk_load,
  output logic       bulk_busy,
  output logic       redraw
);
  localparam int IW = $clog2(N_ENTRIES);

  logic          busy, host_we, dig_we, idx_en, comp_we, start;
  logic [7:0]    dig_rd;
  logic          dig_chg;
  logic [7:0]    idx_q;
  logic          ld_we, fire, tbl_diff;
  logic [IW-1:0] ld_idx;
  logic          t_we;
  logic [IW-1:0] t_idx;
  logic [2:0]    t_mask;
  pal_ent_t      t_val, rent;
  logic [COMP_W-1:0] nib;
  logic          redraw_q, redraw_d;

  always_comb begin
    host_we = wr_en && !busy;
    dig_we  = host_we && !analog_en;
    idx_en  = host_we && analog_en && (addr == 2'd0);
    comp_we = host_we && analog_en && (addr != 2'd0);
    start   = bulk_load && !busy;
  end

  pal_digital u_dig (
    .clk(clk), .rst_n(rst_n), .we(dig_we), .port(addr),
    .wdata(wdata), .rd(dig_rd), .chg(dig_chg)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= wdata;
  end

  pal_bulk #(.N_ENTRIES(N_ENTRIES)) u_bulk (
    .clk(clk), .rst_n(rst_n), .start(start), .tbl_diff(tbl_diff),
    .busy(busy), .ld_we(ld_we), .ld_idx(ld_idx), .fire(fire)
  );

  // table write source: bulk sequencer has priority over the host
  always_comb begin
    if (ld_we) begin
      t_we   = 1'b1;
      t_idx  = ld_idx;
      t_mask = 3'b111;
      t_val  = dflt_entry(32'(ld_idx));
    end else begin
      t_we   = comp_we;
      t_idx  = idx_q[IW-1:0];
      t_val  = {3{wdata[COMP_W-1:0]}};
      unique case (addr)
        2'd1:    t_mask = 3'b100;
        2'd2:    t_mask = 3'b010;
        2'd3:    t_mask = 3'b001;
        default: t_mask = 3'b000;
      endcase
    end
  end

  pal_table #(.N_ENTRIES(N_ENTRIES)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(t_we), .widx(t_idx), .wmask(t_mask),
    .wval(t_val), .ridx(idx_q[IW-1:0]), .rent(rent), .diff(tbl_diff)
  );

  always_comb begin
    unique case (addr)
      2'd1:    nib = rent[3*COMP_W-1:2*COMP_W];
      2'd2:    nib = rent[2*COMP_W-1:COMP_W];
      default: nib = rent[COMP_W-1:0];
    endcase
    if (!analog_en)         rdata = dig_rd;
    else if (addr == 2'd0)  rdata = idx_q;
    else                    rdata = {{(8-COMP_W){1'b0}}, nib};
    redraw_d = dig_chg || (comp_we && tbl_diff) || fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) redraw_q <= 1'b0;
    else        redraw_q <= redraw_d;
  end

  assign redraw    = redraw_q;
  assign bulk_busy = busy;
endmodule

// File: rtl/pal_regfile_chk.sv
module pal_regfile_chk #(
  parameter int N_ENTRIES = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       analog_en,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       bulk_busy,
  input logic       redraw,
  input logic [7:0] idx_q
);
  localparam int RW = $clog2(N_ENTRIES + 1) + 1;
  logic [RW-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_len <= '0;
    else if (bulk_busy) run_len <= run_len + 1'b1;
    else                run_len <= '0;
  end

  p_bulk_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bulk_busy) |-> (run_len == RW'(N_ENTRIES)));

  p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bulk_busy |=> $stable(idx_q));

  p_redraw_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    redraw |-> ($past(wr_en && !bulk_busy) || $past(bulk_busy)));

  p_dig_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !analog_en && !bulk_busy && (((rdata ^ wdata) & 8'h77) == 8'h00))
      |=> !redraw);

  p_dig_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !analog_en && !bulk_busy && (((rdata ^ wdata) & 8'h77) != 8'h00))
      |=> redraw);

  p_ana_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && analog_en && !bulk_busy && (addr != 2'd0) && (rdata[3:0] == wdata[3:0]))
      |=> !redraw);

  p_ana_hi_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (analog_en && (addr != 2'd0)) |-> (rdata[7:4] == 4'h0));
endmodule

bind pal_regfile pal_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n), .analog_en(analog_en), .wr_en(wr_en),
  .addr(addr), .wdata(wdata), .rdata(rdata), .bulk_busy(bulk_busy),
  .redraw(redraw), .idx_q(idx_q)
);

// File: tb/sim_pal_regfile.sv
module sim_pal_regfile;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       analog_en, wr_en, bulk_load;
  logic [1:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       bulk_busy, redraw;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  logic [7:0]  m_dig [4];
  logic [11:0] m_ana [16];
  logic [7:0]  m_idx;

  always #10 clk = ~clk;

  pal_regfile u0 (
    .clk(clk), .rst_n(rst_n), .analog_en(analog_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .bulk_load(bulk_load),
    .bulk_busy(bulk_busy), .redraw(redraw)
  );

  function automatic logic [11:0] dflt(input int i);
    int lvl;
    if (i == 8) return 12'h444;
    lvl = (i < 8) ? 7 : 15;
    return 12'((((i >> 2) & 1) * lvl) * 256 + (((i >> 1) & 1) * lvl) * 16 + (i & 1) * lvl);
  endfunction

  function automatic int slot_of(input int a);
    return (a == 0) ? 3 : (a == 3) ? 0 : a;
  endfunction

  function automatic logic [7:0] exp_rd(input int a);
    if (!analog_en) return m_dig[slot_of(a)];
    if (a == 0) return m_idx;
    return 8'((m_ana[m_idx & 8'hf] >> ((3 - a) * 4)) & 12'hf);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(input int a, input string tag);
    addr = 2'(a);
    #1;
    chk(tag, 32'(rdata), 32'(exp_rd(a)));
  endtask

  task automatic wr(input int a, input logic [7:0] d, input string tag);
    logic er;
    int   s, sh;
    if (!analog_en) begin
      s  = slot_of(a);
      er = (((m_dig[s] ^ d) & 8'h77) != 0);
      m_dig[s] = d;
    end else if (a == 0) begin
      er = 1'b0;
      m_idx = d;
    end else begin
      sh = (3 - a) * 4;
      er = (((m_ana[m_idx & 8'hf] >> sh) & 12'hf) != 12'(d & 8'hf));
      m_ana[m_idx & 8'hf] = (m_ana[m_idx & 8'hf] & ~(12'hf << sh)) | (12'(d & 8'hf) << sh);
    end
    addr = 2'(a); wdata = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    chk(tag, 32'(redraw), 32'(er));
  endtask

  task automatic bulk(input bit hammer);
    int  n;
    bit  ef;
    ef = 1'b0;
    for (int i = 0; i < 16; i++) if (m_ana[i] != dflt(i)) ef = 1'b1;
    n = 0;
    bulk_load = 1'b1;
    @(posedge clk); @(negedge clk);
    bulk_load = 1'b0;
    while (bulk_busy && n < 40) begin
      chk("R9 no redraw while busy", 32'(redraw), 0);
      if (hammer) begin
        wr_en = 1'b1; addr = 2'(n % 4); wdata = 8'(8'hff ^ n);
      end
      @(posedge clk); @(negedge clk);
      n++;
    end
    wr_en = 1'b0;
    chk("R8 busy length", 32'(n), 16);
    chk("R8 final redraw", 32'(redraw), 32'(ef));
    for (int i = 0; i < 16; i++) m_ana[i] = dflt(i);
  endtask

  task automatic sweep_table(input string tag);
    for (int i = 0; i < 16; i++) begin
      wr(0, 8'(i), tag);
      for (int a = 1; a < 4; a++) rd_chk(a, tag);
    end
  endtask

  initial begin
    #(20 * 150000);
    nbad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; analog_en = 1'b0; wr_en = 1'b0; bulk_load = 1'b0;
    addr = 2'd0; wdata = 8'h00;
    for (int b = 0; b < 4; b++) m_dig[b] = 8'(8'h04 + 8'h11 * b);
    for (int i = 0; i < 16; i++) m_ana[i] = dflt(i);
    m_idx = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    chk("R1 redraw idle", 32'(redraw), 0);
    chk("R1 busy idle", 32'(bulk_busy), 0);
    for (int a = 0; a < 4; a++) rd_chk(a, "R1 digital reset");
    analog_en = 1'b1;
    rd_chk(0, "R1 index reset");
    sweep_table("R7 default table");

    // R2/R3 digital sweep
    analog_en = 1'b0;
    for (int a = 0; a < 4; a++) begin
      for (int k = 0; k < 8; k++) begin
        if (k % 2 == 0) wr(a, m_dig[slot_of(a)] ^ 8'h88, "R3 masked bits only");
        else            wr(a, 8'(a * 37 + k * 29 + 1), "R3 digital change");
        for (int p = 0; p < 4; p++) rd_chk(p, "R2 slot mapping");
      end
      wr(a, m_dig[slot_of(a)], "R3 same value");
    end

    // R4/R5/R6/R11 analog sweep
    analog_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      wr(0, 8'(i | (((i * 3) & 15) << 4)), "R4 index write");
      rd_chk(0, "R4 index readback");
      for (int a = 1; a < 4; a++) begin
        wr(a, 8'(i * 7 + a * 3), "R6 component change");
        rd_chk(a, "R5 component readback");
        wr(a, {~rdata[7:4] | 4'h5, rdata[3:0]}, "R6 same nibble");
      end
    end
    wr(0, 8'hf3, "R11 high index bits");
    wr(1, 8'h0a, "R11 write via alias");
    wr(0, 8'h03, "R11 plain index");
    rd_chk(1, "R11 alias same entry");

    // R10 personalities independent
    analog_en = 1'b0;
    for (int a = 0; a < 4; a++) rd_chk(a, "R10 digital untouched");
    wr(1, 8'h5a, "R10 digital write");
    wr(3, 8'h21, "R10 digital write");
    analog_en = 1'b1;
    sweep_table("R10 table untouched");

    // R8/R9 bulk reload with host traffic
    wr(0, 8'h4c, "R9 set index");
    bulk(1'b1);
    rd_chk(0, "R9 index kept");
    sweep_table("R8 table reloaded");
    bulk(1'b0);
    analog_en = 1'b0;
    bulk(1'b1);
    for (int a = 0; a < 4; a++) rd_chk(a, "R9 digital kept");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule